// File: doc/BRIEF.md
# Mailbox Interrupt Dual-Port RAM

A synchronous two-port memory of 4096 words (9 bits by default) in which a left and a right port each read and write any location on their own, in the same clock cycle if they wish. Each port has an enable, an output enable, a write strobe, an address and separate write and read data buses. A read is captured into a per-port output register at the clock edge, so data appears one cycle after the request.

The two highest addresses double as mailboxes for signalling between the ports. The left port posts a message to the right by writing the top address, which drives the right port's active-low interrupt. The right port posts to the left through the address just below the top. The receiving port clears its interrupt by reading its mailbox. The message itself is ordinary stored data, read back like any other word.

Top module: `mbox_dpram`

## Requirements
- R1: Every location written by either port holds that value and is returned on either port's read data bus after the clock edge that samples the read.
- R2: A read takes place only when the port's enable and output enable are both high and its write strobe is low; in any other cycle that port's read data bus keeps its previous value.
- R3: When one port reads a location in the same cycle the other port writes it, the read returns the old contents; a read in a later cycle returns the new data.
- R4: A left-port write (enable and write strobe high) to the top address (all address bits 1) drives `r_int_no` low from the clock edge of that write.
- R5: A right-port read of the top address drives `r_int_no` back high from the clock edge of that read.
- R6: A right-port write to the address one below the top drives `l_int_no` low; a left-port read of that address drives it high again.
- R7: A mailbox read by the port that wrote it, or a receiving-port access with output enable low, leaves the interrupt unchanged.
- R8: If the setting write and the clearing read of the same interrupt fall in one cycle, the interrupt ends up active (low).
- R9: After reset both interrupt outputs are high (inactive) and both read data buses are zero.
- R10: The words at the two mailbox addresses are stored and read back as plain data.
- R11: Writes to any non-mailbox address, or a port writing its own incoming mailbox, change neither interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_en_i | input | 1 | Left port enable |
| l_oe_i | input | 1 | Left port output enable |
| l_we_i | input | 1 | Left port write strobe |
| l_addr_i | input | ADDR_W | Left port address |
| l_wdata_i | input | DATA_W | Left port write data |
| l_rdata_o | output | DATA_W | Left port read data, registered |
| l_int_no | output | 1 | Left port interrupt, active low |
| r_en_i | input | 1 | Right port enable |
| r_oe_i | input | 1 | Right port output enable |
| r_we_i | input | 1 | Right port write strobe |
| r_addr_i | input | ADDR_W | Right port address |
| r_wdata_i | input | DATA_W | Right port write data |
| r_rdata_o | output | DATA_W | Right port read data, registered |
| r_int_no | output | 1 | Right port interrupt, active low |

## Verification
The hardest case to reach is the cycle where one port posts to a mailbox while the other port reads the same mailbox, since both the interrupt priority and the read-during-write data are decided in that single edge. The bench drives both ports in the same cycle on the mailbox address and checks that the interrupt stays asserted and that the reader sees the earlier message, then reads again to see the new one and release the interrupt. A reduced 16-word configuration lets every address be written and read from both sides.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned NUM_PORTS = 2;
  typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;
endpackage

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set has priority
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R4 / R6: posting raises the flag
  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) set_i |=> flag_o);
  // R5: clearing read drops it
  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && !set_i) |=> !flag_o);
  // R8: set beats clear
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) (set_i && clr_i) |=> flag_o);
  // R7: no event, no change
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wr_i,
  input  logic [1:0]        rd_i,
  input  logic [ADDR_W-1:0] addr_i  [2],
  input  logic [DATA_W-1:0] wdata_i [2],
  output logic [DATA_W-1:0] rdata_o [2]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Right write is applied last when both ports hit one word.
  always_ff @(posedge clk_i) begin
    if (wr_i[0]) mem_q[addr_i[0]] <= wdata_i[0];
    if (wr_i[1]) mem_q[addr_i[1]] <= wdata_i[1];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_o[p] <= '0;
      else if (rd_i[p])  rdata_o[p] <= mem_q[addr_i[p]];  // pre-write contents
    end

    p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                   !rd_i[p] |=> $stable(rdata_o[p]));
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_en_i,
  input  logic              l_oe_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_int_no,
  input  logic              r_en_i,
  input  logic              r_oe_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_int_no
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [1:0]        wr, rd, set, clr, flag;
  logic [ADDR_W-1:0] addr  [NUM_PORTS];
  logic [DATA_W-1:0] wdata [NUM_PORTS];
  logic [DATA_W-1:0] rdata [NUM_PORTS];
  logic [ADDR_W-1:0] inbox [NUM_PORTS];

  always_comb begin
    wr[PORT_L]    = l_en_i & l_we_i;
    wr[PORT_R]    = r_en_i & r_we_i;
    rd[PORT_L]    = l_en_i & l_oe_i & ~l_we_i;
    rd[PORT_R]    = r_en_i & r_oe_i & ~r_we_i;
    addr[PORT_L]  = l_addr_i;
    addr[PORT_R]  = r_addr_i;
    wdata[PORT_L] = l_wdata_i;
    wdata[PORT_R] = r_wdata_i;
    inbox[PORT_L] = TOP_ADDR - 1'b1;
    inbox[PORT_R] = TOP_ADDR;
  end

  mbox_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .rd_i    (rd),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_int
    localparam int unsigned Q = NUM_PORTS - 1 - p;  // sending port
    assign set[p] = wr[Q] && (addr[Q] == inbox[p]);
    assign clr[p] = rd[p] && (addr[p] == inbox[p]);

    mbox_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set[p]),
      .clr_i  (clr[p]),
      .flag_o (flag[p])
    );
  end

  assign l_rdata_o = rdata[PORT_L];
  assign r_rdata_o = rdata[PORT_R];
  assign l_int_no  = ~flag[PORT_L];
  assign r_int_no  = ~flag[PORT_R];

  // R11: non-mailbox writes leave the right interrupt alone
  p_no_stray_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(l_en_i && l_we_i && l_addr_i == TOP_ADDR) && !(r_en_i && r_oe_i && !r_we_i && r_addr_i == TOP_ADDR))
    |=> $stable(r_int_no));
endmodule

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 9;
  localparam int unsigned N  = 1 << AW;
  localparam logic [AW-1:0] TOP = '1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic l_en_i = 0, l_oe_i = 0, l_we_i = 0;
  logic r_en_i = 0, r_oe_i = 0, r_we_i = 0;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic [DW-1:0] l_wdata_i = '0, r_wdata_i = '0;
  logic [DW-1:0] l_rdata_o, r_rdata_o;
  logic l_int_no, r_int_no;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbox_dpram (.*);

  function automatic logic [DW-1:0] pat_l(int a);
    return DW'((a * 37 + 11) % 512);
  endfunction
  function automatic logic [DW-1:0] pat_r(int a);
    return DW'((a * 53 + 200) % 512);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic idle();
    l_en_i = 0; l_oe_i = 0; l_we_i = 0;
    r_en_i = 0; r_oe_i = 0; r_we_i = 0;
  endtask

  task automatic l_set(logic en, logic oe, logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    l_en_i = en; l_oe_i = oe; l_we_i = we; l_addr_i = a; l_wdata_i = d;
  endtask
  task automatic r_set(logic en, logic oe, logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    r_en_i = en; r_oe_i = oe; r_we_i = we; r_addr_i = a; r_wdata_i = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    // R9: reset state
    chk("R9 l_int", l_int_no, 1);
    chk("R9 r_int", r_int_no, 1);
    chk("R9 l_rdata", l_rdata_o, 0);
    chk("R9 r_rdata", r_rdata_o, 0);

    // R1/R10: left fills, right reads back
    for (int a = 0; a < N; a++) begin
      l_set(1, 0, 1, AW'(a), pat_l(a)); step();
    end
    idle();
    chk("R4 r_int after sweep", r_int_no, 0);
    chk("R11 l_int after left sweep", l_int_no, 1);
    for (int a = 0; a < N; a++) begin
      r_set(1, 1, 0, AW'(a), '0); step();
      chk("R1 right readback", r_rdata_o, pat_l(a));
    end
    idle();
    chk("R5 r_int cleared by sweep", r_int_no, 1);

    // R1/R10: right fills, left reads back
    for (int a = 0; a < N; a++) begin
      r_set(1, 0, 1, AW'(a), pat_r(a)); step();
    end
    idle();
    chk("R6 l_int after sweep", l_int_no, 0);
    chk("R11 r_int after right sweep", r_int_no, 1);
    for (int a = 0; a < N; a++) begin
      l_set(1, 1, 0, AW'(a), '0); step();
      chk("R1 left readback", l_rdata_o, pat_r(a));
    end
    idle();
    chk("R6 l_int cleared by sweep", l_int_no, 1);

    // R2: read gating
    l_set(1, 1, 0, 4'd3, '0); step();
    chk("R2 read 3", l_rdata_o, pat_r(3));
    l_set(1, 0, 0, 4'd5, '0); step();
    chk("R2 oe low holds", l_rdata_o, pat_r(3));
    l_set(0, 1, 0, 4'd5, '0); step();
    chk("R2 en low holds", l_rdata_o, pat_r(3));
    l_set(1, 1, 1, 4'd5, 9'h0AA); step();
    chk("R2 write holds", l_rdata_o, pat_r(3));
    idle();

    // R3: cross-port read during write
    l_set(1, 0, 1, 4'd7, 9'h155);
    r_set(1, 1, 0, 4'd7, '0); step();
    chk("R3 old data", r_rdata_o, pat_r(7));
    idle();
    r_set(1, 1, 0, 4'd7, '0); step();
    chk("R3 new data", r_rdata_o, 9'h155);
    idle();

    // R4/R7: post to right, non-clearing accesses
    l_set(1, 0, 1, TOP, 9'h1C3); step(); idle();
    chk("R4 r_int set", r_int_no, 0);
    l_set(1, 1, 0, TOP, '0); step(); idle();
    chk("R7 sender read keeps", r_int_no, 0);
    chk("R10 sender reads message", l_rdata_o, 9'h1C3);
    r_set(1, 0, 0, TOP, '0); step(); idle();
    chk("R7 oe low keeps", r_int_no, 0);
    r_set(0, 1, 0, TOP, '0); step(); idle();
    chk("R7 en low keeps", r_int_no, 0);
    r_set(1, 1, 0, TOP, '0); step(); idle();
    chk("R5 r_int cleared", r_int_no, 1);
    chk("R10 message", r_rdata_o, 9'h1C3);

    // R8: set and clear together
    l_set(1, 0, 1, TOP, 9'h011); step(); idle();
    l_set(1, 0, 1, TOP, 9'h022);
    r_set(1, 1, 0, TOP, '0); step(); idle();
    chk("R8 set wins", r_int_no, 0);
    chk("R8 reader sees earlier", r_rdata_o, 9'h011);
    r_set(1, 1, 0, TOP, '0); step(); idle();
    chk("R8 later clear", r_int_no, 1);
    chk("R8 new message", r_rdata_o, 9'h022);

    // R6/R11: left side mailbox and stray writes
    l_set(1, 0, 1, TOP - 1'b1, 9'h0F0); step(); idle();
    chk("R11 own inbox write", l_int_no, 1);
    chk("R11 no right effect", r_int_no, 1);
    r_set(1, 0, 1, TOP, 9'h033); step(); idle();
    chk("R11 right writes own inbox", r_int_no, 1);
    chk("R11 l_int untouched", l_int_no, 1);
    r_set(1, 0, 1, TOP - 1'b1, 9'h077); step(); idle();
    chk("R6 l_int set", l_int_no, 0);
    r_set(1, 1, 0, TOP - 1'b1, '0); step(); idle();
    chk("R7 right reads own post", l_int_no, 0);
    l_set(1, 1, 0, TOP - 1'b1, '0); step(); idle();
    chk("R6 l_int cleared", l_int_no, 1);
    chk("R10 left message", l_rdata_o, 9'h077);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule